// File: doc/BRIEF.md
# Receive Character Store Gate

This block sits between a serial receiver's deserializer and its receive FIFO. Each completed character arrives with a one-cycle valid strobe. The block then decides three things for that character: whether it is written into the FIFO, whether it counts for special-character matching, and whether it raises an XON or XOFF pulse for in-band flow control.

A receiver-off control selects the behaviour. When the receiver is off, the deserializer keeps its framing, but characters are neither stored nor matched against the special code. XON and XOFF are still recognised and pulsed. A change to the receiver-off control never splits a character. The block holds its own registered copy of the setting and reloads it only while the line is idle or on the strobe that closes a character.

Top module: `rx_store_gate`

## Requirements
- R1: While the latched setting is enabled, each valid strobe produces a one-cycle `fifo_wr` in the same cycle as the strobe.
- R2: While the latched setting is off, a valid strobe produces no `fifo_wr`, whatever the character value.
- R3: A character equal to `xon_code` raises `xon_hit`, and one equal to `xoff_code` raises `xoff_hit`. Each pulse lasts one cycle, in the same cycle as the strobe, whether the receiver is on or off.
- R4: `spec_hit` pulses with the strobe when the character equals `spec_code` and the latched setting is enabled. It stays low while the setting is off.
- R5: If `rx_off` changes while `chr_busy` is high and no strobe is present, the character in progress keeps the old setting. The new setting applies from the following character.
- R6: While `chr_busy` is low, a change of `rx_off` takes effect for a strobe one or more cycles later.
- R7: Reset sets the latched setting to enabled. A character that completes after reset without any idle cycle is therefore stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_valid | input | 1 | One-cycle strobe: a character is complete |
| chr_data | input | DW | Completed character |
| chr_busy | input | 1 | A character is being received |
| rx_off | input | 1 | Requested receiver-off setting |
| xon_code | input | DW | Configured XON value |
| xoff_code | input | DW | Configured XOFF value |
| spec_code | input | DW | Configured special character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| xon_hit | output | 1 | XON detected pulse |
| xoff_hit | output | 1 | XOFF detected pulse |
| spec_hit | output | 1 | Special character detected pulse |

## Verification
The bench builds the block with the default `DW` of 8. It sets XON, XOFF and special codes that are distinct, so every combination of character kind and receiver setting can be reached through the ports. With 8-bit characters, the same byte values serve both the vector table and the directed sequences. These sequences flip `rx_off` in the middle of a character, flip it while the line is idle, and release reset in the middle of a character.

// File: rtl/rx_store_gate.sv
module rx_store_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_busy,
  input  logic          rx_off,
  input  logic [DW-1:0] xon_code,
  input  logic [DW-1:0] xoff_code,
  input  logic [DW-1:0] spec_code,
  output logic          fifo_wr,
  output logic          xon_hit,
  output logic          xoff_hit,
  output logic          spec_hit
);

  logic off_q;
  logic load_ok;

  assign load_ok = !chr_busy || chr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= 1'b0;
    else if (load_ok) off_q <= rx_off;
  end

  assign fifo_wr  = chr_valid && !off_q;
  assign xon_hit  = chr_valid && (chr_data == xon_code);
  assign xoff_hit = chr_valid && (chr_data == xoff_code);
  assign spec_hit = fifo_wr && (chr_data == spec_code);

  // R5
  hold_mid_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_busy && !chr_valid) |=> $stable(off_q));

  // R6
  wr_tracks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_ok) && chr_valid) |-> (fifo_wr == !$past(rx_off)));

  // R4
  spec_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |-> fifo_wr);

  // R3
  flow_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_hit || xoff_hit) |-> chr_valid);

  // R1
  wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !$past(chr_valid) && $past(rst_n)) |=> !fifo_wr || chr_valid);

endmodule

// File: tb/rx_store_gate_bench.sv
`timescale 1ns/1ps
module rx_store_gate_bench;
  localparam int DW = 8;
  localparam logic [7:0] XON = 8'h11, XOFF = 8'h13, SPEC = 8'h7E;
  // {off, data[7:0], wr, xon, xoff, spec}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 8'h41, 4'b1000}, {1'b0, 8'h11, 4'b1100},
    {1'b0, 8'h13, 4'b1010}, {1'b0, 8'h7E, 4'b1001},
    {1'b1, 8'h41, 4'b0000}, {1'b1, 8'h11, 4'b0100},
    {1'b1, 8'h13, 4'b0010}, {1'b1, 8'h7E, 4'b0000}
  };

  logic clk = 0, rst_n = 0;
  logic chr_valid = 0, chr_busy = 0, rx_off = 0;
  logic [DW-1:0] chr_data = '0;
  logic fifo_wr, xon_hit, xoff_hit, spec_hit;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_store_gate #(.DW(DW)) u_rx_store_gate (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_busy(chr_busy), .rx_off(rx_off), .xon_code(XON), .xoff_code(XOFF),
    .spec_code(SPEC), .fifo_wr(fifo_wr), .xon_hit(xon_hit),
    .xoff_hit(xoff_hit), .spec_hit(spec_hit));

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {fifo_wr, xon_hit, xoff_hit, spec_hit};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {wr,xon,xoff,spec} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Receives one character; optionally flips rx_off midway. Checks the strobe cycle and the one after.
  task automatic rx_char(input logic [7:0] d, input bit flip, input bit newoff,
                         input string tag, input logic [3:0] exp);
    @(negedge clk) chr_busy = 1;
    repeat (3) @(negedge clk);
    if (flip) rx_off = newoff;
    repeat (2) @(negedge clk);
    chr_valid = 1; chr_data = d;
    #1 check(tag, exp);
    @(negedge clk) chr_valid = 0; chr_busy = 0;
    #1 check({tag, " R3 pulse ends"}, 4'b0000);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: request off and a character in progress during reset
    rx_off = 1; chr_busy = 1;
    repeat (3) @(negedge clk);
    #1 check("R7 reset idle outputs", 4'b0000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chr_valid = 1; chr_data = 8'h55;
    #1 check("R7 stored after reset", 4'b1000);
    @(negedge clk) chr_valid = 0; chr_busy = 0;

    // R1 R2 R3 R4 table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) rx_off = VEC[i][12];
      repeat (2) @(negedge clk);
      rx_char(VEC[i][11:4], 0, 0, $sformatf("R1 R2 R3 R4 vector %0d", i), VEC[i][3:0]);
    end

    // R5: enabled then flip to off mid-character
    @(negedge clk) rx_off = 0;
    repeat (2) @(negedge clk);
    rx_char(8'h7E, 1, 1, "R5 old setting kept (on)", 4'b1001);
    rx_char(8'h7E, 0, 0, "R5 new setting (off)", 4'b0000);
    rx_char(8'h13, 1, 0, "R5 old setting kept (off)", 4'b0010);
    rx_char(8'h41, 0, 0, "R5 new setting (on)", 4'b1000);

    // R6: idle change, strobe right after with busy low
    @(negedge clk) rx_off = 1;
    @(negedge clk) chr_valid = 1; chr_data = 8'h41;
    #1 check("R6 idle change applied", 4'b0000);
    @(negedge clk) rx_off = 0; chr_valid = 0;
    @(negedge clk) chr_valid = 1; chr_data = 8'h11;
    #1 check("R6 idle re-enable applied", 4'b1100);
    @(negedge clk) chr_valid = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule